// File: doc/BRIEF.md
# ADC Sample FIFO and Acquisition Control Registers

This block is the host-facing register set of a multi-channel analog input front end. A host on a simple synchronous bus selects a channel and a gain code and picks what starts each conversion: a software strobe, a pacer tick or the rising edge of an external trigger. Optional auto-scan walks the channels from 0 up to the programmed channel. Every finished conversion is pushed into a deep sample FIFO, which the host drains by reading one address.

Two level-sensitive interrupt lines report activity. The FIFO line fires on end of conversion or on half full. The trigger line fires on a pacer tick or on an external edge. A strobe write drops both lines.

The analog converter is modelled by a stub. Its result arrives a fixed number of cycles after a start pulse and carries the channel number in its top four bits and the `analog_in` value below them. A conversion sequencer runs through the states IDLE, START, WAIT and STORE:
- IDLE goes to START when the selected trigger fires.
- START pulses the stub and moves to WAIT.
- WAIT goes to STORE when the stub reports a valid result.
- STORE pushes the sample and returns to IDLE.

A second small machine watches writes of the FIFO-enable bit to empty the FIFO. It has the states NONE, SAW_LOW and SAW_HIGH:
- A write of 0 moves it to SAW_LOW, or clears the FIFO when it comes from SAW_HIGH.
- A write of 1 moves SAW_LOW to SAW_HIGH and sends any other state to NONE.

Top module: `adc_acq_regs`

## Requirements
- R1: After reset the status byte (offset 0x08) reads 0x0060, the trigger-control readback (0x0A) reads 0, both interrupt lines are low and the FIFO is empty.
- R2: A write to 0x08 changes only status bits 2:0 (the gain code). Bits 7:4 keep reflecting converter and FIFO state.
- R3: With trigger-control bits 2:1 both 0, any write to 0x0E starts one conversion. Status bit 7 reads 1 while the conversion runs. The stored sample is {channel[3:0], analog_in[11:0]}. Status bit 4 reads 1 while the FIFO holds data. Reads of 0x00 return samples oldest first.
- R4: Trigger-control bit 1 makes `pacer_tick` start conversions. Otherwise bit 2 makes a rising edge of `ext_trig` start one conversion, and a held-high level starts no more. In either of these modes a write to 0x0E has no effect.
- R5: Channel register 0x06 reads back as written. With trigger-control bit 0 set, successive conversions use channels 0, 1, …, channel register, then wrap to 0. With bit 0 clear, every conversion uses the channel register.
- R6: A read of 0x0A returns the trigger-control bits in bits 2:0 and interrupt-control bits 2:0 in bits 6:4.
- R7: The FIFO is emptied when three consecutive writes to 0x0C carry bit 2 as 0, then 1, then 0. The order 1 then 0 alone leaves the FIFO intact.
- R8: When interrupt-control bit 0 is 0, `irq_fifo` rises after a sample is stored and stays high until any write to 0x48. That write also drops `irq_trig`.
- R9: When interrupt-control bit 0 is 1, `irq_fifo` follows half full (512 or more entries, status bit 5 then reads 0). After a clear it re-asserts on the next cycle if the FIFO is still half full.
- R10: Status bit 6 reads 0 when the FIFO holds 1024 entries. Samples arriving then are dropped. Bit 6 stays 0, even after draining, until the next FIFO reset.
- R11: When interrupt-control bit 1 is 0, `irq_trig` is set by `pacer_tick`. When bit 1 is 1, it is set by a rising edge of `ext_trig`.
- R12: A read of 0x00 with the FIFO empty returns 0 and leaves the FIFO empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after `bus_rd` |
| analog_in | input | 12 | Value the converter stub samples |
| pacer_tick | input | 1 | Pacer timer tick |
| ext_trig | input | 1 | External trigger input |
| irq_fifo | output | 1 | FIFO-event interrupt, level |
| irq_trig | output | 1 | Trigger-event interrupt, level |

## Verification
The hardest states to reach are the FIFO full and sticky-overflow states. Entering them takes more than a thousand stored samples and then extra conversions that must be dropped.

The stimulus issues software-triggered conversions one by one. A bench-side occupancy model decides which expected samples enter the scoreboard. The bench then drains the whole FIFO to prove two things: no dropped sample slipped in, and the full flag still reads as lost data until the reset sequence is written. The half-full re-assert is caught on the exact cycles around a clear strobe.

// File: rtl/acq_pkg.sv
package acq_pkg;
    localparam int BUS_W = 16;

    localparam logic [7:0] OFS_FIFO = 8'h00;
    localparam logic [7:0] OFS_CHAN = 8'h06;
    localparam logic [7:0] OFS_STAT = 8'h08;
    localparam logic [7:0] OFS_TRIG = 8'h0A;
    localparam logic [7:0] OFS_INTC = 8'h0C;
    localparam logic [7:0] OFS_SOFT = 8'h0E;
    localparam logic [7:0] OFS_ICLR = 8'h48;

    typedef enum logic [1:0] {CV_IDLE, CV_START, CV_WAIT, CV_STORE} cv_state_t;
    typedef enum logic [1:0] {FR_NONE, FR_SAW_LOW, FR_SAW_HIGH} fr_state_t;
endpackage

// File: rtl/acq_fifo.sv
module acq_fifo #(
    parameter int DEPTH = 1024,
    parameter int DW    = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          half,
    output logic          full,
    output logic          ovf
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          push_ok, pop_ok;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign half    = (count >= CW'(DEPTH / 2));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign rdata   = mem[rp];

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok)
            mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            if (push_ok) wp <= step(wp);
            if (pop_ok)  rp <= step(rp);
            if (push_ok && !pop_ok)
                count <= count + 1'b1;
            else if (pop_ok && !push_ok)
                count <= count - 1'b1;
            if (push && full)
                ovf <= 1'b1;
        end
    end
endmodule

// File: rtl/acq_conv_stub.sv
module acq_conv_stub #(
    parameter int LAT = 4,
    parameter int DW  = 16,
    parameter int CHW = 4,
    localparam int TW = $clog2(LAT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CHW-1:0]    chan,
    input  logic [DW-CHW-1:0] analog_in,
    output logic              valid,
    output logic [DW-1:0]     sample
);
    logic [TW-1:0] timer;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timer  <= '0;
            sample <= '0;
        end else if (start) begin
            timer  <= TW'(LAT);
            sample <= {chan, analog_in};
        end else if (timer != '0) begin
            timer  <= timer - 1'b1;
        end
    end

    assign valid = (timer == TW'(1));
endmodule

// File: rtl/acq_seq.sv
module acq_seq
    import acq_pkg::*;
#(
    parameter int CHW = 4,
    parameter int DW  = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           soft_go,
    input  logic           pacer_tick,
    input  logic           ext_rise,
    input  logic           mode_ascan,
    input  logic           mode_pacer,
    input  logic           mode_ext,
    input  logic [CHW-1:0] last_chan,
    input  logic           conv_valid,
    input  logic [DW-1:0]  conv_sample,
    output logic           conv_start,
    output logic [CHW-1:0] conv_chan,
    output logic           busy,
    output logic           push,
    output logic [DW-1:0]  push_data
);
    cv_state_t      state, state_nx;
    logic           fire;
    logic [CHW-1:0] scan_ptr;

    always_comb begin
        if (mode_pacer)      fire = pacer_tick;
        else if (mode_ext)   fire = ext_rise;
        else                 fire = soft_go;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= CV_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            CV_IDLE:  if (fire) state_nx = CV_START;
            CV_START: state_nx = CV_WAIT;
            CV_WAIT:  if (conv_valid) state_nx = CV_STORE;
            CV_STORE: state_nx = CV_IDLE;
        endcase
    end

    always_comb begin
        conv_start = (state == CV_START);
        busy       = (state != CV_IDLE);
        push       = (state == CV_STORE);
        conv_chan  = mode_ascan ? scan_ptr : last_chan;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            push_data <= '0;
            scan_ptr  <= '0;
        end else begin
            if (state == CV_WAIT && conv_valid)
                push_data <= conv_sample;
            if (state == CV_STORE) begin
                if (!mode_ascan || scan_ptr >= last_chan)
                    scan_ptr <= '0;
                else
                    scan_ptr <= scan_ptr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/adc_acq_regs.sv
module adc_acq_regs
    import acq_pkg::*;
#(
    parameter int FIFO_DEPTH = 1024,
    parameter int CHAN_W     = 4,
    parameter int CONV_LAT   = 4,
    localparam int CNT_W     = $clog2(FIFO_DEPTH) + 1,
    localparam int AIN_W     = BUS_W - CHAN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic [AIN_W-1:0] analog_in,
    input  logic             pacer_tick,
    input  logic             ext_trig,
    output logic             irq_fifo,
    output logic             irq_trig
);
    logic [2:0]        gain_q, trig_q, intc_q;
    logic [CHAN_W-1:0] chan_q;
    logic              ext_q, ext_rise;
    logic              wr_chan, wr_stat, wr_trig, wr_intc, wr_soft, wr_iclr;
    fr_state_t         fr_state, fr_nx;
    logic              fifo_clr;

    logic              cv_start, cv_valid, cv_busy, cv_push;
    logic [CHAN_W-1:0] cv_chan;
    logic [BUS_W-1:0]  cv_sample, cv_data;

    logic              fifo_pop, fifo_empty, fifo_half, fifo_full, fifo_ovf;
    logic [BUS_W-1:0]  fifo_rdata;
    logic [CNT_W-1:0]  fifo_cnt;
    logic [BUS_W-1:0]  rd_mux;

    assign wr_chan  = bus_wr && bus_addr == OFS_CHAN;
    assign wr_stat  = bus_wr && bus_addr == OFS_STAT;
    assign wr_trig  = bus_wr && bus_addr == OFS_TRIG;
    assign wr_intc  = bus_wr && bus_addr == OFS_INTC;
    assign wr_soft  = bus_wr && bus_addr == OFS_SOFT;
    assign wr_iclr  = bus_wr && bus_addr == OFS_ICLR;
    assign fifo_pop = bus_rd && bus_addr == OFS_FIFO;
    assign ext_rise = ext_trig && !ext_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain_q <= '0;
            trig_q <= '0;
            intc_q <= '0;
            chan_q <= '0;
            ext_q  <= 1'b0;
        end else begin
            ext_q <= ext_trig;
            if (wr_stat) gain_q <= bus_wdata[2:0];
            if (wr_trig) trig_q <= bus_wdata[2:0];
            if (wr_intc) intc_q <= bus_wdata[2:0];
            if (wr_chan) chan_q <= bus_wdata[CHAN_W-1:0];
        end
    end

    // FIFO-enable write sequence watcher
    always_ff @(posedge clk) begin
        if (!rst_n) fr_state <= FR_NONE;
        else        fr_state <= fr_nx;
    end

    always_comb begin
        fr_nx    = fr_state;
        fifo_clr = 1'b0;
        if (wr_intc) begin
            unique case (fr_state)
                FR_NONE:     fr_nx = bus_wdata[2] ? FR_NONE : FR_SAW_LOW;
                FR_SAW_LOW:  fr_nx = bus_wdata[2] ? FR_SAW_HIGH : FR_SAW_LOW;
                FR_SAW_HIGH: begin
                    fr_nx    = bus_wdata[2] ? FR_NONE : FR_SAW_LOW;
                    fifo_clr = !bus_wdata[2];
                end
                default:     fr_nx = FR_NONE;
            endcase
        end
    end

    acq_seq #(.CHW(CHAN_W), .DW(BUS_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_go    (wr_soft),
        .pacer_tick (pacer_tick),
        .ext_rise   (ext_rise),
        .mode_ascan (trig_q[0]),
        .mode_pacer (trig_q[1]),
        .mode_ext   (trig_q[2]),
        .last_chan  (chan_q),
        .conv_valid (cv_valid),
        .conv_sample(cv_sample),
        .conv_start (cv_start),
        .conv_chan  (cv_chan),
        .busy       (cv_busy),
        .push       (cv_push),
        .push_data  (cv_data)
    );

    acq_conv_stub #(.LAT(CONV_LAT), .DW(BUS_W), .CHW(CHAN_W)) u_conv (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (cv_start),
        .chan     (cv_chan),
        .analog_in(analog_in),
        .valid    (cv_valid),
        .sample   (cv_sample)
    );

    acq_fifo #(.DEPTH(FIFO_DEPTH), .DW(BUS_W)) u_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (fifo_clr),
        .push (cv_push),
        .wdata(cv_data),
        .pop  (fifo_pop),
        .rdata(fifo_rdata),
        .count(fifo_cnt),
        .empty(fifo_empty),
        .half (fifo_half),
        .full (fifo_full),
        .ovf  (fifo_ovf)
    );

    always_comb begin
        unique case (bus_addr)
            OFS_FIFO: rd_mux = fifo_empty ? '0 : fifo_rdata;
            OFS_CHAN: rd_mux = BUS_W'(chan_q);
            OFS_STAT: rd_mux = {8'h00, cv_busy, !(fifo_full || fifo_ovf),
                                !fifo_half, !fifo_empty, 1'b0, gain_q};
            OFS_TRIG: rd_mux = {9'h000, intc_q, 1'b0, trig_q};
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            irq_fifo  <= 1'b0;
            irq_trig  <= 1'b0;
        end else begin
            if (bus_rd) bus_rdata <= rd_mux;
            if (wr_iclr) begin
                irq_fifo <= 1'b0;
                irq_trig <= 1'b0;
            end else begin
                if (intc_q[0] ? fifo_half : cv_push)     irq_fifo <= 1'b1;
                if (intc_q[1] ? ext_rise  : pacer_tick)  irq_trig <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/acq_regs_chk.sv
module acq_regs_chk #(
    parameter int DEPTH = 1024,
    parameter int CW    = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic [7:0]    bus_addr,
    input logic          irq_fifo,
    input logic          irq_trig,
    input logic [CW-1:0] fifo_cnt,
    input logic          fifo_ovf,
    input logic          fifo_clr
);
    logic clr_wr;
    assign clr_wr = bus_wr && bus_addr == 8'h48;

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> (!irq_fifo && !irq_trig));

    assert_fifo_irq_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_fifo && !clr_wr) |=> irq_fifo);

    assert_trig_irq_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_trig && !clr_wr) |=> irq_trig);

    assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_ovf && !fifo_clr) |=> fifo_ovf);

    assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fifo_cnt) <= DEPTH);

    assert_reset_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> (fifo_cnt == '0 && !fifo_ovf));
endmodule

bind adc_acq_regs acq_regs_chk #(.DEPTH(FIFO_DEPTH), .CW(CNT_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .irq_fifo(irq_fifo),
    .irq_trig(irq_trig),
    .fifo_cnt(fifo_cnt),
    .fifo_ovf(fifo_ovf),
    .fifo_clr(fifo_clr)
);

// File: tb/adc_acq_regs_tb_top.sv
`timescale 1ns/1ps
module adc_acq_regs_tb_top;
    localparam int DEPTH = 1024;
    localparam int LAT   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [11:0] ain = 12'hABC;
    logic        pacer_tick = 1'b0, ext_trig = 1'b0;
    logic        irq_fifo, irq_trig;

    always #2 clk = ~clk;

    adc_acq_regs #(.FIFO_DEPTH(DEPTH), .CHAN_W(4), .CONV_LAT(LAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .analog_in(ain), .pacer_tick(pacer_tick), .ext_trig(ext_trig),
        .irq_fifo(irq_fifo), .irq_trig(irq_trig)
    );

    int total = 0, bad = 0, mcnt = 0;
    logic [15:0] exp_q[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: one software conversion, expected item into the scoreboard
    task automatic soft_conv(input logic [3:0] ch);
        wr(8'h0E, 16'h0);
        idle(LAT + 6);
        if (mcnt < DEPTH) begin
            exp_q.push_back({ch, ain});
            mcnt++;
        end
    endtask

    // monitor side: pop the design's FIFO and compare with the scoreboard
    task automatic pop_check(input string req);
        logic [15:0] d, e;
        rd(8'h00, d);
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 16'h0;
        if (mcnt > 0) mcnt--;
        check(d == e, req, d, e);
    endtask

    task automatic fifo_reset();
        wr(8'h0C, 16'h0); wr(8'h0C, 16'h4); wr(8'h0C, 16'h0);
        exp_q.delete(); mcnt = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rd(8'h08, v); check(v == 16'h0060, "R1 status", v, 16'h0060);
        rd(8'h0A, v); check(v == 16'h0000, "R1 trigctl", v, 0);
        check(!irq_fifo && !irq_trig, "R1 irqs", {irq_fifo, irq_trig}, 0);

        // R2 gain write touches only bits 2:0
        wr(8'h08, 16'hFFFB);
        rd(8'h08, v); check(v == 16'h0063, "R2 gain", v, 16'h0063);

        // R5 channel readback
        wr(8'h06, 16'h0005);
        rd(8'h06, v); check(v == 16'h0005, "R5 chan readback", v, 5);

        // R3 software conversion, busy bit, FIFO order
        wr(8'h0E, 16'h1234);
        rd(8'h08, v); check(v[7] == 1'b1, "R3 busy", v, 16'h00E3);
        idle(LAT + 6);
        exp_q.push_back({4'h5, ain}); mcnt++;
        rd(8'h08, v); check(v[4] == 1'b1, "R3 nonempty", v, 16'h0073);
        ain = 12'h123;
        soft_conv(4'h5);
        pop_check("R3 first sample");
        pop_check("R3 second sample");
        rd(8'h08, v); check(v[4] == 1'b0, "R3 empty after pops", v, 16'h0063);

        // R12 read of empty FIFO
        rd(8'h00, v); check(v == 16'h0, "R12 empty read", v, 0);
        rd(8'h08, v); check(v[4] == 1'b0, "R12 still empty", v, 16'h0063);

        // R7 FIFO reset needs 0,1,0 on enable bit
        soft_conv(4'h5);
        wr(8'h0C, 16'h4); wr(8'h0C, 16'h0);
        rd(8'h08, v); check(v[4] == 1'b1, "R7 partial sequence keeps data", v, 16'h0073);
        wr(8'h0C, 16'h4); wr(8'h0C, 16'h0);
        exp_q.delete(); mcnt = 0;
        rd(8'h08, v); check(v[4] == 1'b0, "R7 sequence empties", v, 16'h0063);

        // R4 pacer mode ignores soft strobe
        wr(8'h0A, 16'h0002);
        wr(8'h0E, 16'h0); idle(LAT + 6);
        rd(8'h08, v); check(v[4] == 1'b0, "R4 soft ignored in pacer mode", v, 16'h0063);
        @(negedge clk); pacer_tick = 1'b1; @(negedge clk); pacer_tick = 1'b0;
        idle(LAT + 6); exp_q.push_back({4'h5, ain}); mcnt++;
        pop_check("R4 pacer conversion");

        // R4 external edge mode, level held high converts once
        wr(8'h0A, 16'h0004);
        @(negedge clk); ext_trig = 1'b1; idle(30); ext_trig = 1'b0;
        exp_q.push_back({4'h5, ain}); mcnt++;
        pop_check("R4 ext edge conversion");
        rd(8'h08, v); check(v[4] == 1'b0, "R4 held level single conversion", v, 16'h0063);
        wr(8'h0E, 16'h0); idle(LAT + 6);
        rd(8'h08, v); check(v[4] == 1'b0, "R4 soft ignored in ext mode", v, 16'h0063);

        // R5 auto-scan 0..2 wraps
        wr(8'h06, 16'h0002);
        wr(8'h0A, 16'h0001);
        soft_conv(4'h0); soft_conv(4'h1); soft_conv(4'h2); soft_conv(4'h0);
        for (int i = 0; i < 4; i++) pop_check("R5 scan order");
        wr(8'h0A, 16'h0000);
        soft_conv(4'h2);
        pop_check("R5 fixed channel");

        // R6 trigger-control readback
        wr(8'h0C, 16'h0003);
        wr(8'h0A, 16'h0005);
        rd(8'h0A, v); check(v == 16'h0035, "R6 readback", v, 16'h0035);
        wr(8'h0A, 16'h0000);

        // R8 end-of-conversion interrupt
        wr(8'h0C, 16'h0000);
        wr(8'h48, 16'h0);
        check(!irq_fifo && !irq_trig, "R8 cleared", {irq_fifo, irq_trig}, 0);
        soft_conv(4'h2);
        check(irq_fifo, "R8 eoc raises irq", irq_fifo, 1);
        idle(5); check(irq_fifo, "R8 irq level holds", irq_fifo, 1);
        wr(8'h48, 16'hFFFF);
        check(!irq_fifo, "R8 clear drops irq", irq_fifo, 0);
        idle(3); check(!irq_fifo, "R8 stays clear", irq_fifo, 0);
        pop_check("R8 sample");

        // R11 trigger interrupt sources
        @(negedge clk); pacer_tick = 1'b1; @(negedge clk); pacer_tick = 1'b0;
        idle(LAT + 6);
        check(irq_trig, "R11 pacer sets irq_trig", irq_trig, 1);
        check(exp_q.size() == 0, "R11 no conversion in soft mode", exp_q.size(), 0);
        wr(8'h48, 16'h0);
        check(!irq_trig, "R11 clear", irq_trig, 0);
        wr(8'h0C, 16'h0002);
        @(negedge clk); pacer_tick = 1'b1; @(negedge clk); pacer_tick = 1'b0;
        idle(2); check(!irq_trig, "R11 pacer ignored with ext source", irq_trig, 0);
        @(negedge clk); ext_trig = 1'b1; idle(2); ext_trig = 1'b0;
        check(irq_trig, "R11 ext sets irq_trig", irq_trig, 1);
        rd(8'h08, v); check(v[4] == 1'b0, "R11 no conversion", v, 16'h0063);

        // R9 half-full interrupt
        fifo_reset();
        wr(8'h0C, 16'h0001);
        wr(8'h48, 16'h0);
        for (int i = 0; i < DEPTH / 2 - 1; i++) soft_conv(4'h2);
        rd(8'h08, v); check(v[5] == 1'b1, "R9 below half", v, 16'h0073);
        check(!irq_fifo, "R9 no irq below half", irq_fifo, 0);
        soft_conv(4'h2);
        rd(8'h08, v); check(v[5] == 1'b0, "R9 half flag", v, 16'h0053);
        check(irq_fifo, "R9 irq at half", irq_fifo, 1);
        wr(8'h48, 16'h0);
        check(!irq_fifo, "R9 clear cycle", irq_fifo, 0);
        idle(1);
        check(irq_fifo, "R9 re-assert", irq_fifo, 1);

        // R10 full, drop, sticky
        for (int i = 0; i < DEPTH / 2; i++) soft_conv(4'h2);
        rd(8'h08, v); check(v[6] == 1'b0, "R10 full flag", v, 16'h0013);
        ain = 12'h777;
        for (int i = 0; i < 3; i++) soft_conv(4'h2);
        pop_check("R10 head after overflow");
        rd(8'h08, v); check(v[6] == 1'b0, "R10 sticky after pop", v, 16'h0013);
        while (exp_q.size() > 0) pop_check("R10 drain order");
        rd(8'h08, v); check(v[4] == 1'b0, "R10 dropped samples absent", v, 16'h0023);
        check(v[6] == 1'b0, "R10 sticky when empty", v, 16'h0023);
        fifo_reset();
        rd(8'h08, v); check(v[6] == 1'b1, "R10 reset clears flag", v, 16'h0063);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule